// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master

This block is a serial master port that moves data words between a pair of small FIFOs and four serial pins: bit clock, frame, data out and data in. One shift engine serves three framing protocols, selected by a field in a single control register. The three are a chip-select style format where the frame pin is held low for the whole word, a pulse-synchronised format where a one-bit-long high pulse on the frame pin announces each word, and a command/response format where a command word is shifted out and then a response word is shifted in under one frame.

Software writes the control register to choose the word length, the protocol, the bit-rate divisor, the command length and the bit-clock reference. The reference is either an internal tick input or the rising edges of an external clock pin. It then pushes words into the transmit FIFO. A frame starts whenever the port is enabled and the transmit FIFO holds a word. Each received word lands right-justified in the receive FIFO. Clearing the enable bit abandons the frame in progress and empties both FIFOs. The rest of the configuration is kept.

Top module: `sermst_top`

## Requirements
- R1: After reset the control register reads 0 (port disabled), sclk and mosi are 0, frame is 1, busy is 0, tx_not_full is 1 and rx_not_empty is 0.
- R2: Control bits [5:4] = 00 selects the chip-select format. Frame idles high and is low for the whole word. The frame carries exactly one sclk rising edge per data bit.
- R3: Control bits [5:4] = 01 selects the pulse-synchronised format. Frame idles low and is high for exactly the first bit period of the frame, a sync bit with mosi 0 and no received data. The N data bits follow with frame low.
- R4: Control bits [5:4] = 10 selects the command/response format. Frame is low for the whole exchange. Control bit 16 picks the command length C (0: 8 bits, 1: 16 bits). The low C bits of the transmit word go out MSB first. Then N bits are received with mosi held at 0.
- R5: Control bits [3:0] hold the word length N minus one, for N from 4 to 16. Only the low N bits of a transmit word are sent, MSB first. A received word is right-justified with zeros above bit N-1.
- R6: sclk idles low, mosi is valid at each sclk rising edge, and miso is sampled on that edge.
- R7: Control bits [15:8] hold a divisor D. One bit period lasts 2*(D+1) reference ticks, so with a tick on every clock the sclk rising edges are 2*(D+1) clocks apart.
- R8: Control bit 6 selects the reference. With 0, the reference is the int_ref_tick input. With 1, it is each rising edge of ext_clk after a two-flop synchroniser, and int_ref_tick has no effect.
- R9: A write that keeps bit 7 set while the port is already enabled leaves bit 6 unchanged. Bit 6 may be set in the same write that sets bit 7.
- R10: Clearing control bit 7 stops the frame in progress one clock after the write. sclk drops to 0, frame returns to idle, busy goes low and both FIFOs are emptied. All other control fields are kept as written.
- R11: The transmit FIFO holds DEPTH words and tx_not_full is 0 when it is full. A push while it is full or while the port is disabled is dropped. A frame starts when the port is enabled and the FIFO is not empty. busy is 1 throughout each frame.
- R12: At the end of each frame the received word is pushed into the receive FIFO. rx_data shows the oldest word while rx_not_empty is 1, and rx_pop removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 17 | Control register write value |
| cfg_rdata | output | 17 | Control register contents |
| int_ref_tick | input | 1 | Internal reference tick, one clock wide |
| ext_clk | input | 1 | External reference clock pin |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | 16 | Transmit word, right-justified |
| tx_not_full | output | 1 | Transmit FIFO has room |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_data | output | 16 | Head of the receive FIFO |
| rx_not_empty | output | 1 | Receive FIFO holds a word |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial bit clock |
| frame | output | 1 | Frame / chip-select pin |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with DEPTH = 4, so a stalled external clock and five pushes fill the transmit FIFO and show a dropped sixth push within a few dozen cycles. It holds int_ref_tick high, so a half bit lasts D+1 clocks and the bit period in every protocol and word length can be measured directly in clocks. A slave model drives miso from a 32-bit pattern indexed by the sclk rising-edge count. This lets the sync bit and the command/response split be seen in the received word.

// File: rtl/sermst_pkg.sv
package sermst_pkg;
  localparam int DW    = 16;            // widest word
  localparam int SZW   = 4;             // word-length field width
  localparam int SCRW  = 8;             // divisor field width
  localparam int CFG_W = 1 + SCRW + 1 + 1 + 2 + SZW;

  typedef enum logic [1:0] {
    FMT_CS    = 2'b00,
    FMT_SYNC  = 2'b01,
    FMT_CMDRS = 2'b10,
    FMT_RSVD  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic            cmd16;    // [16]
    logic [SCRW-1:0] div;      // [15:8]
    logic            en;       // [7]
    logic            ext_sel;  // [6]
    fmt_e            fmt;      // [5:4]
    logic [SZW-1:0]  len_m1;   // [3:0]
  } cfg_t;
endpackage

// File: rtl/sermst_fifo.sv
module sermst_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_full,
  output logic         not_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign not_full  = (cnt_q != CW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign do_push   = push & not_full & ~flush;
  assign do_pop    = pop & not_empty & ~flush;
  assign dout      = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = bump(wp_q);
      if (do_pop)  rp_d = bump(rp_q);
      if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/sermst_divider.sv
module sermst_divider #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          use_ext,
  input  logic          int_tick,
  input  logic          ext_clk,
  input  logic [RW-1:0] div,
  output logic          half_tick
);
  logic [1:0]    sync_q;
  logic          prev_q;
  logic [RW-1:0] cnt_q, cnt_d;
  logic          ref_tick;

  assign ref_tick = use_ext ? (sync_q[1] & ~prev_q) : int_tick;

  always_comb begin
    cnt_d     = cnt_q;
    half_tick = 1'b0;
    if (!run) begin
      cnt_d = '0;                       // divider held while no frame runs
    end else if (ref_tick) begin
      if (cnt_q == div) begin
        cnt_d     = '0;
        half_tick = 1'b1;
      end else begin
        cnt_d = cnt_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], ext_clk};
      prev_q <= sync_q[1];
      cnt_q  <= cnt_d;
    end
  end

  assert_ext_edge_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && use_ext && half_tick) |-> (sync_q[1] && !prev_q));
endmodule

// File: rtl/sermst_shifter.sv
module sermst_shifter
  import sermst_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  fmt_e           fmt,
  input  logic [SZW-1:0] len_m1,
  input  logic           cmd16,
  input  logic           half_tick,
  input  logic           tx_avail,
  input  logic [DW-1:0]  tx_word,
  input  logic           miso,
  output logic           tx_pop,
  output logic           rx_push,
  output logic [DW-1:0]  rx_word,
  output logic           active,
  output logic           sclk,
  output logic           frame,
  output logic           mosi
);
  localparam int BW = $clog2(2 * DW + 1);

  logic          act_q, act_d, ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] txs_q, txs_d, rxs_q, rxs_d;
  logic [BW-1:0] nlen, clen, total, lsh;
  logic          tx_bit, rx_bit;

  // Per-protocol frame layout: length and which bit slots drive/sample.
  always_comb begin
    nlen = BW'(len_m1) + BW'(1);
    clen = cmd16 ? BW'(16) : BW'(8);
    unique case (fmt)
      FMT_SYNC: begin
        total  = nlen + BW'(1);
        tx_bit = (bit_q != '0);
        rx_bit = (bit_q != '0);
        lsh    = BW'(DW) - nlen;
      end
      FMT_CMDRS: begin
        total  = clen + nlen;
        tx_bit = (bit_q < clen);
        rx_bit = (bit_q >= clen);
        lsh    = BW'(DW) - clen;
      end
      default: begin
        total  = nlen;
        tx_bit = 1'b1;
        rx_bit = 1'b1;
        lsh    = BW'(DW) - nlen;
      end
    endcase
  end

  always_comb begin
    act_d   = act_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    txs_d   = txs_q;
    rxs_d   = rxs_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    if (!en) begin
      act_d = 1'b0;
      ph_d  = 1'b0;
    end else if (!act_q) begin
      if (tx_avail) begin
        tx_pop = 1'b1;
        act_d  = 1'b1;
        ph_d   = 1'b0;
        bit_d  = '0;
        txs_d  = tx_word << lsh;
        rxs_d  = '0;
      end
    end else if (half_tick) begin
      if (!ph_q) begin
        ph_d = 1'b1;                                  // rising edge: sample
        if (rx_bit) rxs_d = {rxs_q[DW-2:0], miso};
      end else begin
        ph_d = 1'b0;                                  // falling edge: advance
        if (tx_bit) txs_d = {txs_q[DW-2:0], 1'b0};
        if (bit_q == total - BW'(1)) begin
          act_d   = 1'b0;
          rx_push = 1'b1;
        end else begin
          bit_d = bit_q + BW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 1'b0;
      bit_q <= '0;
      txs_q <= '0;
      rxs_q <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      txs_q <= txs_d;
      rxs_q <= rxs_d;
    end
  end

  assign active  = act_q;
  assign rx_word = rxs_q;
  assign sclk    = act_q & ph_q;
  assign mosi    = act_q & tx_bit & txs_q[DW-1];
  assign frame   = (fmt == FMT_SYNC) ? (act_q && bit_q == '0) : ~act_q;

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!act_q && !sclk));
  assert_edge_paced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(half_tick));
  assert_word_closes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !act_q);
endmodule

// File: rtl/sermst_top.sv
module sermst_top
  import sermst_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             int_ref_tick,
  input  logic             ext_clk,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_not_full,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_data,
  output logic             rx_not_empty,
  output logic             busy,
  output logic             sclk,
  output logic             frame,
  output logic             mosi,
  input  logic             miso
);
  cfg_t          cfg_q, cfg_d;
  logic          tx_avail, tx_pop, rx_push, half_tick, active;
  logic [DW-1:0] tx_head, rx_word;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d = cfg_t'(cfg_wdata);
      if (cfg_q.en && cfg_d.en) cfg_d.ext_sel = cfg_q.ext_sel;  // no source swap while running
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_rdata = cfg_q;
  assign busy      = active;

  sermst_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(~cfg_q.en),
    .push(tx_push & cfg_q.en), .din(tx_data),
    .pop(tx_pop), .dout(tx_head),
    .not_full(tx_not_full), .not_empty(tx_avail)
  );

  sermst_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(~cfg_q.en),
    .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_data),
    .not_full(), .not_empty(rx_not_empty)
  );

  sermst_divider #(.RW(SCRW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(active & cfg_q.en),
    .use_ext(cfg_q.ext_sel), .int_tick(int_ref_tick), .ext_clk(ext_clk),
    .div(cfg_q.div), .half_tick(half_tick)
  );

  sermst_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .fmt(cfg_q.fmt),
    .len_m1(cfg_q.len_m1), .cmd16(cfg_q.cmd16), .half_tick(half_tick),
    .tx_avail(tx_avail), .tx_word(tx_head), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .active(active),
    .sclk(sclk), .frame(frame), .mosi(mosi)
  );

  assert_source_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && $past(cfg_q.en)) |-> $stable(cfg_q.ext_sel));
endmodule

// File: tb/sermst_top_test.sv
`timescale 1ns/1ps
module sermst_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic [16:0] cfg_rdata;
  logic        int_ref_tick = 1'b1;
  logic        ext_clk = 1'b0;
  logic        tx_push = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_not_full, rx_pop = 1'b0, rx_not_empty, busy;
  logic [15:0] rx_data;
  logic        sclk, frame, mosi, miso;

  int nchk = 0, nerr = 0, cyc = 0, rise_cnt = 0, last_rise = 0, period = 0, frames = 0;
  logic [31:0] pat = '0, mosi_cap = '0, frame_cap = '0;
  bit done = 0;

  sermst_top #(.DEPTH(4)) uut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;
  assign miso = (rise_cnt < 32) ? pat[31 - rise_cnt] : 1'b0;
  always @(posedge sclk) begin
    mosi_cap  = {mosi_cap[30:0], mosi};
    frame_cap = {frame_cap[30:0], frame};
    if (rise_cnt > 0) period = cyc - last_rise;
    last_rise = cyc;
    rise_cnt++;
  end
  always @(negedge busy) frames++;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [3:0]  lm1;
    logic        c16;
    logic [7:0]  dv;
    logic [15:0] tx;
    logic [31:0] pt;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 4'd7,  1'b0, 8'd0, 16'h00A5, 32'hC300_0000},
    '{2'b00, 4'd15, 1'b0, 8'd2, 16'hBEEF, 32'h1234_0000},
    '{2'b00, 4'd3,  1'b0, 8'd1, 16'hFFF9, 32'hA000_0000},
    '{2'b01, 4'd7,  1'b0, 8'd1, 16'h003C, 32'h5A80_0000},
    '{2'b10, 4'd7,  1'b0, 8'd0, 16'h0081, 32'h0096_0000},
    '{2'b10, 4'd11, 1'b1, 8'd0, 16'h1357, 32'h0000_ABC0},
    '{2'b01, 4'd15, 1'b0, 8'd0, 16'h8001, 32'h7FFF_8000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] mk(input logic c16, input logic [7:0] dv, input logic en,
                                     input logic ex, input logic [1:0] f, input logic [3:0] l);
    return {c16, dv, en, ex, f, l};
  endfunction

  task automatic wr_cfg(input logic [16:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk); tx_push = 1'b1; tx_data = v;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic clear_caps(input logic [31:0] p);
    pat = p; rise_cnt = 0; mosi_cap = '0; frame_cap = '0; period = 0;
  endtask

  task automatic wait_frame_done();
    int n = 0;
    while (!busy && n < 200)   begin @(negedge clk); n++; end
    n = 0;
    while (busy && n < 20000)  begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      repeat (3) @(negedge clk); ext_clk = 1'b1;
      repeat (3) @(negedge clk); ext_clk = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] n, c, exp_rx, exp_mo, exp_fr, exp_t, sh;
    logic [16:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg",   32'(cfg_rdata), 0);
    check("R1 sclk",  {31'd0, sclk}, 0);
    check("R1 frame", {31'd0, frame}, 1);
    check("R1 busy",  {31'd0, busy}, 0);
    check("R1 txnf",  {31'd0, tx_not_full}, 1);
    check("R1 rxne",  {31'd0, rx_not_empty}, 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R12
    for (int i = 0; i < NV; i++) begin
      n = 32'(VECS[i].lm1) + 1;
      c = VECS[i].c16 ? 16 : 8;
      unique case (VECS[i].fmt)
        2'b01: begin sh = 1; exp_t = n + 1; exp_fr = 32'd1 << n;
                     exp_mo = 32'(VECS[i].tx) & ((32'd1 << n) - 1); end
        2'b10: begin sh = c; exp_t = c + n; exp_fr = 0;
                     exp_mo = (32'(VECS[i].tx) & ((32'd1 << c) - 1)) << n; end
        default: begin sh = 0; exp_t = n; exp_fr = 0;
                     exp_mo = 32'(VECS[i].tx) & ((32'd1 << n) - 1); end
      endcase
      exp_rx = (VECS[i].pt << sh) >> (32 - n);
      wr_cfg(mk(VECS[i].c16, VECS[i].dv, 1'b1, 1'b0, VECS[i].fmt, VECS[i].lm1));
      clear_caps(VECS[i].pt);
      push(VECS[i].tx);
      wait_frame_done();
      check("R2/R3/R4 edges", rise_cnt, exp_t);
      check("R5/R6 mosi bits", mosi_cap, exp_mo);
      check("R2/R3/R4 frame", frame_cap, exp_fr);
      check("R7 bit period", period, 2 * (32'(VECS[i].dv) + 1));
      check("R6 sclk idle", {31'd0, sclk}, 0);
      check("R12 rx ready", {31'd0, rx_not_empty}, 1);
      check("R5/R12 rx word", 32'(rx_data), exp_rx);
      @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    end

    // R8 external reference, set together with enable (R9)
    wr_cfg(mk(1'b0, 8'd0, 1'b0, 1'b0, 2'b00, 4'd3));
    wr_cfg(mk(1'b0, 8'd0, 1'b1, 1'b1, 2'b00, 4'd3));
    check("R9 ext set with enable", {31'd0, cfg_rdata[6]}, 1);
    clear_caps(32'h9000_0000);
    push(16'h0006);
    repeat (40) @(negedge clk);
    check("R8 internal tick ignored", rise_cnt, 0);
    check("R8 waiting busy", {31'd0, busy}, 1);
    ext_pulses(10);
    wait_frame_done();
    check("R8 ext edges", rise_cnt, 4);
    check("R8 ext mosi", mosi_cap, 32'h6);
    check("R8 ext rx", 32'(rx_data), 32'h9);
    // R9 source change while enabled is ignored
    wr_cfg(mk(1'b0, 8'd0, 1'b1, 1'b0, 2'b00, 4'd3));
    check("R9 hold ext_sel", {31'd0, cfg_rdata[6]}, 1);
    wr_cfg(mk(1'b0, 8'd0, 1'b0, 1'b0, 2'b00, 4'd3));
    check("R9 cleared when disabling", 32'(cfg_rdata), 32'(mk(1'b0, 8'd0, 1'b0, 1'b0, 2'b00, 4'd3)));

    // R11 transmit FIFO full with a stalled external reference
    wr_cfg(mk(1'b0, 8'd0, 1'b1, 1'b1, 2'b00, 4'd3));
    clear_caps(32'h0);
    for (int k = 0; k < 5; k++) push(16'(k + 1));
    check("R11 tx full", {31'd0, tx_not_full}, 0);
    push(16'h000F);
    frames = 0;
    ext_pulses(60);
    repeat (20) @(negedge clk);
    check("R11 extra push dropped", frames, 5);
    check("R11 idle after drain", {31'd0, busy}, 0);

    // R11 push while disabled is dropped
    wr_cfg(mk(1'b0, 8'd0, 1'b0, 1'b0, 2'b00, 4'd3));
    push(16'h0005);
    wr_cfg(mk(1'b0, 8'd0, 1'b1, 1'b0, 2'b00, 4'd3));
    repeat (20) @(negedge clk);
    check("R11 disabled push dropped", {31'd0, busy}, 0);

    // R10 abort mid-frame
    v = mk(1'b0, 8'd20, 1'b1, 1'b0, 2'b00, 4'd15);
    wr_cfg(v);
    clear_caps(32'hFFFF_FFFF);
    push(16'h1111);
    push(16'h2222);
    repeat (30) @(negedge clk);
    check("R10 mid-frame busy", {31'd0, busy}, 1);
    check("R10 mid-frame frame", {31'd0, frame}, 0);
    v[7] = 1'b0;
    wr_cfg(v);
    @(negedge clk);
    check("R10 busy cleared", {31'd0, busy}, 0);
    check("R10 sclk low", {31'd0, sclk}, 0);
    check("R10 frame idle", {31'd0, frame}, 1);
    check("R10 tx flushed", {31'd0, tx_not_full}, 1);
    check("R10 rx empty", {31'd0, rx_not_empty}, 0);
    check("R10 config kept", 32'(cfg_rdata), 32'(v));
    v[7] = 1'b1;
    wr_cfg(v);
    repeat (60) @(negedge clk);
    check("R10 pending word flushed", {31'd0, busy}, 0);
    finish_run();
  end
endmodule